// File: doc/BRIEF.md
# Interlocked Bus Memory Target

This block puts a small word-organised memory on an asynchronous, interlocked parallel bus. Every bus line is wired-low. The master presents an address, a two-bit transfer code and, for writes, data. It then asserts its strobe. The target decodes its own address window and performs the transfer. It answers with its own strobe and keeps that strobe until the master drops its strobe. On reads it also reports whether the word it returned is trustworthy.

All bus inputs reach the block already synchronised to `clk` and still in their active-low line form. Each line the target can pull is a separate pull-enable output. A 1 on a pull output means "pull this line low", and the block never drives any line high. The handshake is the flow control. The target takes a transfer only while the master strobe is asserted, and it cannot stall the master except by delaying its own strobe. There is no valid/ready stream at this edge.

A read-with-pause locks the word it reads. The next transfer to this target must be a word or byte write to the same word. If it is not, a sticky violation flag is set. A bus initialise request returns the block to idle, releases every line and drops the lock.

Top module: `ubt_slave_target`

## Requirements
- R1: After reset, no line is pulled: slave strobe, all data pulls, both parity pulls and the violation flag are 0.
- R2: On a word read (code value C1,C0 = 00) to a written word, the data pulls carry the stored word, where pull bit = 1 means data bit = 1. The data is present at least one cycle before the slave strobe is pulled.
- R3: On a word write (code 10), the word is stored and the slave strobe is pulled one cycle after the master strobe is first sampled asserted.
- R4: On a byte write (code 11), address bit 0 = 1 stores data bits 15:8 into the upper byte, and address bit 0 = 0 stores bits 7:0 into the lower byte. The other byte of the word is unchanged.
- R5: The slave strobe stays pulled for as long as the master strobe stays asserted. It and the data pulls are released on the clock after the master strobe is negated.
- R6: An address outside [BASE_ADDR, BASE_ADDR + 2*WORDS) is ignored. It causes no slave strobe, no data pull and no store.
- R7: Parity report: line B is pulled during a read or read-with-pause of a word that was never written since reset, and the data pulls are then 0. Line B stays released for a written word and on every write. Line A is never pulled.
- R8: A read-with-pause (code 01) returns data like a word read. A write to the same word as the next transfer leaves the violation flag at 0.
- R9: After a read-with-pause, if the next transfer to this target is not a write to the same word, the violation flag is set and stays set until reset.
- R10: While bus initialise is asserted, the next clock returns the block to idle, releases every pulled line and clears the pause lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_init_l | input | 1 | Bus initialise line, active low, synchronised |
| bus_addr_l | input | 18 | Address lines, active low |
| bus_ctl_l | input | 2 | Transfer code lines [1]=C1 [0]=C0, active low |
| bus_data_l | input | 16 | Data lines as sampled, active low |
| bus_mstrobe_l | input | 1 | Master strobe, active low |
| data_pull | output | 16 | Pull-enable per data line |
| sstrobe_pull | output | 1 | Pull-enable for the slave strobe |
| par_a_pull | output | 1 | Pull-enable for parity line A (never set) |
| par_b_pull | output | 1 | Pull-enable for parity line B (slave error) |
| lock_err | output | 1 | Sticky read-with-pause violation flag |

## Verification
The hardest situation to reach is an initialise request that arrives while a transfer is stalled with both strobes pulled, combined with a pause lock that is still pending. The bench reaches the first case by holding the master strobe asserted after the slave answers and then pulsing initialise. It reaches the second by issuing a read-with-pause, initialising while the bus is idle, and then sending an unrelated read. That read must leave the violation flag clear. The byte-lane paths are covered by first filling a word with a known pattern, then writing each lane separately and reading the whole word back.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  // Transfer code as a value (lines inverted): {C1,C0}
  typedef enum logic [1:0] {
    XF_READ       = 2'b00,
    XF_READ_PAUSE = 2'b01,
    XF_WRITE      = 2'b10,
    XF_WRITE_BYTE = 2'b11
  } xfer_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_HOLD  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/ubt_window_decode.sv
module ubt_window_decode #(
  parameter int              AW        = 18,
  parameter int              WORDS     = 64,
  parameter logic [AW-1:0]   BASE_ADDR = 18'h3E000,
  localparam int             IDX_W     = $clog2(WORDS)
) (
  input  logic [AW-1:0]    addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             lane_hi
);
  localparam logic [AW-1:0] WIN_BYTES = AW'(2 * WORDS);

  logic [AW-1:0] offset;

  always_comb begin
    offset  = addr - BASE_ADDR;
    hit     = (addr >= BASE_ADDR) && (offset < WIN_BYTES);
    idx     = offset[IDX_W:1];
    lane_hi = offset[0]; // BASE_ADDR is even, so this is address bit 0
  end
endmodule

// File: rtl/ubt_word_store.sv
module ubt_word_store #(
  parameter int  DW    = 16,
  parameter int  WORDS = 64,
  localparam int IDX_W = $clog2(WORDS),
  localparam int HB    = DW / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  input  logic             wr_en,
  input  logic             wr_byte,
  input  logic             wr_hi,
  input  logic [DW-1:0]    wr_data
);
  logic [DW-1:0]    mem [WORDS];
  logic [WORDS-1:0] written;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) written <= '0;
    else if (wr_en) written[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (!wr_byte)   mem[idx]         <= wr_data;
      else if (wr_hi) mem[idx][DW-1:HB] <= wr_data[DW-1:HB];
      else            mem[idx][HB-1:0]  <= wr_data[HB-1:0];
    end
  end

  always_comb begin
    rd_valid = written[idx];
    rd_data  = rd_valid ? mem[idx] : '0;
  end

  // R4: a byte write leaves the opposite lane untouched
  a_r4_other_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte && wr_hi && written[idx]) |=>
      (mem[$past(idx)][HB-1:0] == $past(mem[idx][HB-1:0])));
  a_r4_upper_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte && !wr_hi && written[idx]) |=>
      (mem[$past(idx)][DW-1:HB] == $past(mem[idx][DW-1:HB])));
endmodule

// File: rtl/ubt_pause_lock.sv
module ubt_pause_lock
  import ubt_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  xfer_e            xfer,
  input  logic [IDX_W-1:0] idx,
  output logic             locked,
  output logic             lock_err
);
  logic [IDX_W-1:0] lk_idx;
  logic             is_wr;

  assign is_wr = (xfer == XF_WRITE) || (xfer == XF_WRITE_BYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      lk_idx   <= '0;
      lock_err <= 1'b0;
    end else if (clr) begin
      locked <= 1'b0;
    end else if (start) begin
      if (locked && !(is_wr && idx == lk_idx)) lock_err <= 1'b1;
      locked <= (xfer == XF_READ_PAUSE);
      lk_idx <= idx;
    end
  end

  // R9: a read following a pause is always a violation
  a_r9_read_after_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clr && locked && !is_wr) |=> lock_err);
  // R9: the flag is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |=> lock_err);
endmodule

// File: rtl/ubt_slave_target.sv
module ubt_slave_target
  import ubt_pkg::*;
#(
  parameter int            AW        = 18,
  parameter int            DW        = 16,
  parameter int            WORDS     = 64,
  parameter logic [AW-1:0] BASE_ADDR = 18'h3E000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_init_l,
  input  logic [AW-1:0] bus_addr_l,
  input  logic [1:0]    bus_ctl_l,
  input  logic [DW-1:0] bus_data_l,
  input  logic          bus_mstrobe_l,
  output logic [DW-1:0] data_pull,
  output logic          sstrobe_pull,
  output logic          par_a_pull,
  output logic          par_b_pull,
  output logic          lock_err
);
  localparam int IDX_W = $clog2(WORDS);

  hs_state_e        state;
  logic             init, mreq, hit, lane_hi, rd_valid, start, locked;
  logic             is_wr, is_byte;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    rd_data;
  xfer_e            xfer;

  assign init    = ~bus_init_l;
  assign mreq    = ~bus_mstrobe_l;
  assign xfer    = xfer_e'(~bus_ctl_l);
  assign is_wr   = xfer[1];
  assign is_byte = (xfer == XF_WRITE_BYTE);
  assign start   = (state == ST_IDLE) && mreq && hit && !init;

  ubt_window_decode #(.AW(AW), .WORDS(WORDS), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(~bus_addr_l), .hit(hit), .idx(idx), .lane_hi(lane_hi)
  );

  ubt_word_store #(.DW(DW), .WORDS(WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(idx), .rd_data(rd_data), .rd_valid(rd_valid),
    .wr_en(start && is_wr), .wr_byte(is_byte), .wr_hi(lane_hi),
    .wr_data(~bus_data_l)
  );

  ubt_pause_lock #(.IDX_W(IDX_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .clr(init), .start(start), .xfer(xfer),
    .idx(idx), .locked(locked), .lock_err(lock_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      data_pull  <= '0;
      par_b_pull <= 1'b0;
    end else if (init) begin
      state      <= ST_IDLE;
      data_pull  <= '0;
      par_b_pull <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          if (is_wr) state <= ST_HOLD;
          else begin
            state      <= ST_SETUP;
            data_pull  <= rd_data;
            par_b_pull <= ~rd_valid;
          end
        end
        ST_SETUP: state <= ST_HOLD;
        ST_HOLD: if (!mreq) begin
          state      <= ST_IDLE;
          data_pull  <= '0;
          par_b_pull <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sstrobe_pull = (state == ST_HOLD);
  assign par_a_pull   = 1'b0;

  // R5: strobe is held while the master keeps its strobe
  a_r5_strobe_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sstrobe_pull && mreq && !init) |=> sstrobe_pull);
  // R5: release of strobe and data after master negation
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (sstrobe_pull && !mreq) |=> (!sstrobe_pull && data_pull == '0));
  // R6: a miss never leaves idle
  a_r6_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !hit) |=> (state == ST_IDLE));
  // R10: initialise releases all lines and the lock
  a_r10_init_release: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (!sstrobe_pull && data_pull == '0 && !par_b_pull && !locked));
  // R7: parity error only reported inside a transfer
  a_r7_perr_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    par_b_pull |-> (state != ST_IDLE));
endmodule

// File: tb/ubt_slave_target_tb.sv
module ubt_slave_target_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [17:0] BASE       = 18'h3E000;
  localparam int          WORDS      = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_init_l = 1'b1;
  logic [17:0] bus_addr_l = '1;
  logic [1:0]  bus_ctl_l = '1;
  logic [15:0] bus_data_l = '1;
  logic        bus_mstrobe_l = 1'b1;
  logic [15:0] data_pull;
  logic        sstrobe_pull, par_a_pull, par_b_pull, lock_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ubt_slave_target dut_i (
    .clk(clk), .rst_n(rst_n), .bus_init_l(bus_init_l), .bus_addr_l(bus_addr_l),
    .bus_ctl_l(bus_ctl_l), .bus_data_l(bus_data_l), .bus_mstrobe_l(bus_mstrobe_l),
    .data_pull(data_pull), .sstrobe_pull(sstrobe_pull), .par_a_pull(par_a_pull),
    .par_b_pull(par_b_pull), .lock_err(lock_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  // One bus transfer as master; returns data seen and parity B at acknowledge.
  task automatic xfer(input logic [17:0] a, input logic [1:0] code,
                      input logic [15:0] wd, input int hold_extra,
                      output logic [15:0] rd, output bit perr, output bit acked);
    logic [15:0] prev;
    prev  = '0;
    acked = 0;
    rd    = '0;
    perr  = 0;
    @(negedge clk);
    bus_addr_l = ~a;
    bus_ctl_l  = ~code;
    bus_data_l = code[1] ? ~wd : '1;
    @(negedge clk);
    bus_mstrobe_l = 1'b0;
    for (int i = 0; i < 6 && !acked; i++) begin
      @(negedge clk);
      if (sstrobe_pull) begin
        acked = 1;
        rd    = data_pull;
        perr  = par_b_pull;
        if (!code[1]) chk(prev == data_pull, "R2", "data before strobe", prev, data_pull);
        if (code[1]) chk(i == 0, "R3", "write ack cycle", i, 0);
        chk(!par_a_pull, "R7", "parity A", par_a_pull, 0);
      end
      prev = data_pull;
    end
    if (acked) begin
      for (int i = 0; i < hold_extra; i++) begin
        @(negedge clk);
        chk(sstrobe_pull, "R5", "strobe held", sstrobe_pull, 1);
      end
    end
    bus_mstrobe_l = 1'b1;
    @(negedge clk);
    chk(!sstrobe_pull && data_pull == 0 && !par_b_pull, "R5", "release",
        {sstrobe_pull, data_pull}, 0);
    bus_addr_l = '1;
    bus_ctl_l  = '1;
    bus_data_l = '1;
  endtask

  function automatic logic [17:0] wa(input int w);
    return BASE + 18'(2 * w);
  endfunction

  task automatic t_reset;
    chk(!sstrobe_pull && data_pull == 0 && !par_a_pull && !par_b_pull && !lock_err,
        "R1", "reset outputs", {sstrobe_pull, par_a_pull, par_b_pull, lock_err}, 0);
  endtask

  task automatic t_word_rw;
    logic [15:0] rd; bit pe, ack;
    xfer(wa(0), 2'b10, 16'h1234, 0, rd, pe, ack);
    chk(ack && !pe, "R3", "write ack", {ack, pe}, 2'b10);
    xfer(wa(63), 2'b10, 16'hF00D, 0, rd, pe, ack);
    xfer(wa(0), 2'b00, 16'h0, 0, rd, pe, ack);
    chk(ack && rd == 16'h1234, "R2", "read word0", rd, 16'h1234);
    chk(!pe, "R7", "no perr on written word", pe, 0);
    xfer(wa(63), 2'b00, 16'h0, 0, rd, pe, ack);
    chk(rd == 16'hF00D, "R2", "read top word", rd, 16'hF00D);
  endtask

  task automatic t_unwritten;
    logic [15:0] rd; bit pe, ack;
    xfer(wa(5), 2'b00, 16'h0, 0, rd, pe, ack);
    chk(ack && pe, "R7", "perr on unwritten", pe, 1);
    chk(rd == 0, "R7", "zero data on unwritten", rd, 0);
  endtask

  task automatic t_byte;
    logic [15:0] rd; bit pe, ack;
    xfer(wa(1), 2'b10, 16'h1111, 0, rd, pe, ack);
    xfer(wa(1) | 18'h1, 2'b11, 16'hAB22, 0, rd, pe, ack);
    xfer(wa(1), 2'b00, 16'h0, 0, rd, pe, ack);
    chk(rd == 16'hAB11, "R4", "upper lane", rd, 16'hAB11);
    xfer(wa(1), 2'b11, 16'h33CD, 0, rd, pe, ack);
    xfer(wa(1), 2'b00, 16'h0, 0, rd, pe, ack);
    chk(rd == 16'hABCD, "R4", "lower lane", rd, 16'hABCD);
  endtask

  task automatic t_window;
    logic [15:0] rd; bit pe, ack;
    xfer(BASE + 18'(2 * WORDS), 2'b10, 16'hDEAD, 0, rd, pe, ack);
    chk(!ack, "R6", "above window", ack, 0);
    xfer(BASE - 18'd2, 2'b00, 16'h0, 0, rd, pe, ack);
    chk(!ack && rd == 0, "R6", "below window", ack, 0);
    xfer(wa(0), 2'b00, 16'h0, 0, rd, pe, ack);
    chk(rd == 16'h1234, "R6", "no store from miss", rd, 16'h1234);
  endtask

  task automatic t_hold;
    logic [15:0] rd; bit pe, ack;
    xfer(wa(63), 2'b00, 16'h0, 5, rd, pe, ack);
    chk(ack, "R5", "long hold ack", ack, 1);
  endtask

  task automatic t_pause_ok;
    logic [15:0] rd; bit pe, ack;
    xfer(wa(2), 2'b10, 16'h0F0F, 0, rd, pe, ack);
    xfer(wa(2), 2'b01, 16'h0, 0, rd, pe, ack);
    chk(ack && rd == 16'h0F0F, "R8", "pause read data", rd, 16'h0F0F);
    xfer(wa(2), 2'b10, 16'h5555, 0, rd, pe, ack);
    chk(!lock_err, "R8", "no violation", lock_err, 0);
  endtask

  task automatic t_init;
    logic [15:0] rd; bit pe, ack;
    xfer(wa(2), 2'b01, 16'h0, 0, rd, pe, ack);
    @(negedge clk); bus_init_l = 1'b0;
    @(negedge clk); bus_init_l = 1'b1;
    xfer(wa(3), 2'b00, 16'h0, 0, rd, pe, ack);
    chk(!lock_err, "R10", "lock cleared by init", lock_err, 0);
    // initialise during a stalled transfer
    @(negedge clk);
    bus_addr_l = ~wa(0); bus_ctl_l = 2'b11;
    bus_mstrobe_l = 1'b0;
    repeat (3) @(negedge clk);
    chk(sstrobe_pull, "R10", "stalled strobe", sstrobe_pull, 1);
    bus_init_l = 1'b0;
    @(negedge clk);
    chk(!sstrobe_pull && data_pull == 0 && !par_b_pull, "R10", "init release",
        {sstrobe_pull, data_pull}, 0);
    bus_mstrobe_l = 1'b1;
    @(negedge clk); bus_init_l = 1'b1;
    bus_addr_l = '1; bus_ctl_l = '1;
  endtask

  task automatic t_violation;
    logic [15:0] rd; bit pe, ack;
    xfer(wa(2), 2'b01, 16'h0, 0, rd, pe, ack);
    xfer(wa(4), 2'b10, 16'h7777, 0, rd, pe, ack);
    chk(lock_err, "R9", "write to other word", lock_err, 1);
    xfer(wa(0), 2'b00, 16'h0, 0, rd, pe, ack);
    chk(lock_err, "R9", "sticky", lock_err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_rw();
    t_unwritten();
    t_byte();
    t_window();
    t_hold();
    t_pause_ok();
    t_init();
    t_violation();
    finish_run();
  end
endmodule